// File: doc/BRIEF.md
# Serial Control Register and Track Counter

This block is the host-facing control port of a disc playback controller. A host shifts 8-bit command words into it over a data and clock pair, least significant bit first, and then pulses a latch strobe. The upper nibble of the committed word picks one of seven control registers. The lower nibble is the payload. The stored mode nibbles drive the servo and audio logic around the block. That logic is outside this block.

Two of the registers hold the low and high nibbles of an 8-bit track-jump count. Writing either nibble reloads a down-counter with the concatenated value. Each rising edge of an external track pulse then decrements the counter until it reaches zero. A single status output changes meaning with the register addressed last: it shows an active-low done flag, an active-low busy flag, or a pulse-width indication passed through from the servo. For any other register it is released to high impedance through a separate enable. All host and track inputs are asynchronous and are synchronized into the system clock.

Top module: `serial_ctrl_port`

## Requirements
- R1: A word is captured from eight rising edges of `sclk_i` with `sdat_i` sampled LSB first. It is committed on the rising edge of `latch_i`. Bits [7:4] are the register address and bits [3:0] are the payload.
- R2: Address 4'b1001 loads `data_ctrl_o`, 4'b1010 loads `sync_att_o`, and 4'b1101 loads `servo_tune_o`, each with the payload.
- R3: Address 4'b1110 loads `servo_mode_o` only with one of the codes 0000, 0101, 0110, 1000, 1010, 1100, 1110, 1111. Any other payload leaves `servo_mode_o` unchanged.
- R4: Address 4'b1111 sets `double_speed_o` to 1 when payload bits [1:0] are 2'b11 and to 0 for any other payload.
- R5: A write to address 4'b1011 (low nibble) or 4'b1100 (high nibble) reloads `trk_cnt_o` with {high nibble, low nibble}, using the new value of the nibble just written.
- R6: Each rising edge of `trk_pulse_i` decrements `trk_cnt_o` by one. At zero the counter holds, and it changes at no other time.
- R7: When a counter load and a track pulse edge are seen in the same clock cycle, the load wins and that pulse is discarded.
- R8: After a write to 4'b1011, `status_oe_o` is 1 and `status_o` is 0 exactly when `trk_cnt_o` is zero.
- R9: After a write to 4'b1100, `status_oe_o` is 1 and `status_o` is 0 exactly while `trk_cnt_o` is nonzero.
- R10: After a write to 4'b1110, `status_oe_o` is 1 and `status_o` is the inverse of `pw_over_i`. After a write to 4'b1001, 4'b1010, 4'b1101 or 4'b1111, `status_oe_o` is 0 and `status_o` is 0.
- R11: A word whose address is 4'b0000 through 4'b1000 changes no register, no counter value and no status selection.
- R12: After reset every register and the counter are zero. This means stop mode (0000), normal speed, and `status_oe_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host serial clock (async) |
| sdat_i | input | 1 | Host serial data, LSB first (async) |
| latch_i | input | 1 | Commit strobe, rising edge (async) |
| trk_pulse_i | input | 1 | Track crossing pulse (async) |
| pw_over_i | input | 1 | Pulse width over 64 indication from servo |
| data_ctrl_o | output | 4 | Data control nibble |
| sync_att_o | output | 4 | Sync protection / attenuation nibble |
| servo_tune_o | output | 4 | Servo tuning nibble |
| servo_mode_o | output | 4 | Servo mode code |
| double_speed_o | output | 1 | Double speed selected |
| trk_cnt_o | output | 8 | Current track count |
| status_o | output | 1 | Multiplexed status value |
| status_oe_o | output | 1 | Status output enable (0 = high impedance) |

## Verification
A counter reload by the latch strobe and a track pulse edge can land in the same system clock cycle. The bench provokes this by raising `latch_i` and `trk_pulse_i` in the same time step, so that both pass through identical synchronizers and their edges arrive together. It then judges the result: the count must equal the freshly loaded value with no decrement applied. A second pulse sent afterwards must still decrement normally.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;

  localparam int unsigned WORD_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic [NIB_W-1:0] {
    ADR_DATA  = 4'b1001,
    ADR_SYNC  = 4'b1010,
    ADR_TRKLO = 4'b1011,
    ADR_TRKHI = 4'b1100,
    ADR_TUNE  = 4'b1101,
    ADR_SERVO = 4'b1110,
    ADR_SPEED = 4'b1111
  } reg_adr_e;

  typedef enum logic [1:0] {
    STS_OFF  = 2'd0,
    STS_DONE = 2'd1,
    STS_BUSY = 2'd2,
    STS_PW   = 2'd3
  } sts_sel_e;

  function automatic logic servo_code_ok(input logic [NIB_W-1:0] c);
    case (c)
      4'b0000, 4'b0101, 4'b0110, 4'b1000,
      4'b1010, 4'b1100, 4'b1110, 4'b1111: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ctrl_in_sync.sv
module ctrl_in_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);

  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [DEPTH-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[DEPTH-2:0], async_i[g]};
    end
    assign level_o[g] = pipe_q[STAGES-1];
    assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end

endmodule

// File: rtl/ctrl_shifter.sv
module ctrl_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] sh_q;

  // first bit in ends at position 0 after WORD_W shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {bit_i, sh_q[WORD_W-1:1]};
  end

  assign word_o = sh_q;

endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import ctrl_port_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [NIB_W-1:0]  data_ctrl_o,
  output logic [NIB_W-1:0]  sync_att_o,
  output logic [NIB_W-1:0]  servo_tune_o,
  output logic [NIB_W-1:0]  servo_mode_o,
  output logic              double_speed_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output sts_sel_e          sel_o
);

  localparam int unsigned HI_W = CNT_W - NIB_W;

  logic [NIB_W-1:0] adr, dat;
  logic [NIB_W-1:0] data_q, sync_q, tune_q, mode_q, lo_q;
  logic [HI_W-1:0]  hi_q;
  logic             dbl_q;
  sts_sel_e         sel_q;
  logic             wr_lo, wr_hi;

  assign adr = word_i[WORD_W-1:NIB_W];
  assign dat = word_i[NIB_W-1:0];

  assign wr_lo = commit_i && (adr == ADR_TRKLO);
  assign wr_hi = commit_i && (adr == ADR_TRKHI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      sync_q <= '0;
      tune_q <= '0;
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      dbl_q  <= 1'b0;
      sel_q  <= STS_OFF;
    end else if (commit_i) begin
      case (adr)
        ADR_DATA: begin
          data_q <= dat;
          sel_q  <= STS_OFF;
        end
        ADR_SYNC: begin
          sync_q <= dat;
          sel_q  <= STS_OFF;
        end
        ADR_TRKLO: begin
          lo_q  <= dat;
          sel_q <= STS_DONE;
        end
        ADR_TRKHI: begin
          hi_q  <= dat[HI_W-1:0];
          sel_q <= STS_BUSY;
        end
        ADR_TUNE: begin
          tune_q <= dat;
          sel_q  <= STS_OFF;
        end
        ADR_SERVO: begin
          if (servo_code_ok(dat)) mode_q <= dat;
          sel_q <= STS_PW;
        end
        ADR_SPEED: begin
          dbl_q <= &dat[1:0];
          sel_q <= STS_OFF;
        end
        default: ;
      endcase
    end
  end

  assign load_o     = wr_lo | wr_hi;
  assign load_val_o = wr_lo ? {hi_q, dat} : {dat[HI_W-1:0], lo_q};

  assign data_ctrl_o    = data_q;
  assign sync_att_o     = sync_q;
  assign servo_tune_o   = tune_q;
  assign servo_mode_o   = mode_q;
  assign double_speed_o = dbl_q;
  assign sel_o          = sel_q;

endmodule

// File: rtl/trk_down_counter.sv
module trk_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  // load has priority over a coincident step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (step_i && |cnt_q)      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = ~|cnt_q;

endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import ctrl_port_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdat_i,
  input  logic             latch_i,
  input  logic             trk_pulse_i,
  input  logic             pw_over_i,
  output logic [3:0]       data_ctrl_o,
  output logic [3:0]       sync_att_o,
  output logic [3:0]       servo_tune_o,
  output logic [3:0]       servo_mode_o,
  output logic             double_speed_o,
  output logic [CNT_W-1:0] trk_cnt_o,
  output logic             status_o,
  output logic             status_oe_o
);

  localparam int unsigned N_IN = 4;
  localparam int unsigned I_SCK = 0;
  localparam int unsigned I_SDA = 1;
  localparam int unsigned I_LAT = 2;
  localparam int unsigned I_TRK = 3;

  logic [N_IN-1:0]   in_async, in_lvl, in_rise;
  logic [WORD_W-1:0] word_w;
  logic              commit_w, trk_rise_w;
  logic              load_w, zero_w;
  logic [CNT_W-1:0]  load_val_w;
  sts_sel_e          sel_w;

  assign in_async = {trk_pulse_i, latch_i, sdat_i, sclk_i};

  ctrl_in_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (in_async),
    .level_o (in_lvl),
    .rise_o  (in_rise)
  );

  assign commit_w   = in_rise[I_LAT];
  assign trk_rise_w = in_rise[I_TRK];

  ctrl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (in_rise[I_SCK]),
    .bit_i   (in_lvl[I_SDA]),
    .word_o  (word_w)
  );

  ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .commit_i       (commit_w),
    .word_i         (word_w),
    .data_ctrl_o    (data_ctrl_o),
    .sync_att_o     (sync_att_o),
    .servo_tune_o   (servo_tune_o),
    .servo_mode_o   (servo_mode_o),
    .double_speed_o (double_speed_o),
    .load_o         (load_w),
    .load_val_o     (load_val_w),
    .sel_o          (sel_w)
  );

  trk_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .step_i     (trk_rise_w),
    .cnt_o      (trk_cnt_o),
    .zero_o     (zero_w)
  );

  always_comb begin
    unique case (sel_w)
      STS_DONE: status_o = ~zero_w;
      STS_BUSY: status_o = zero_w;
      STS_PW:   status_o = ~pw_over_i;
      default:  status_o = 1'b0;
    endcase
  end

  assign status_oe_o = (sel_w != STS_OFF);

endmodule

// File: rtl/ctrl_port_chk.sv
module ctrl_port_chk
  import ctrl_port_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             commit_i,
  input logic [7:0]       word_i,
  input logic             trk_rise_i,
  input logic [CNT_W-1:0] trk_cnt_i,
  input logic [3:0]       servo_mode_i,
  input logic             status_oe_i
);

  logic [3:0] adr;
  logic       ld;
  assign adr = word_i[7:4];
  assign ld  = commit_i && (adr == ADR_TRKLO || adr == ADR_TRKHI);

  AST_LOAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && adr == ADR_TRKLO) |=> trk_cnt_i[3:0] == $past(word_i[3:0])); // R5
  AST_LOAD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && adr == ADR_TRKHI) |=> trk_cnt_i[CNT_W-1:4] == $past(word_i[CNT_W-5:0])); // R5
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld && trk_rise_i && adr == ADR_TRKLO) |=> trk_cnt_i[3:0] == $past(word_i[3:0])); // R7
  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && trk_rise_i && trk_cnt_i != '0) |=> trk_cnt_i == $past(trk_cnt_i) - 1'b1); // R6
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && trk_cnt_i == '0) |=> trk_cnt_i == '0); // R6
  AST_NO_STRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !trk_rise_i) |=> $stable(trk_cnt_i)); // R6
  AST_BAD_SERVO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && adr == ADR_SERVO && !servo_code_ok(word_i[3:0])) |=> $stable(servo_mode_i)); // R3
  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && (adr == ADR_DATA || adr == ADR_SYNC || adr == ADR_TUNE || adr == ADR_SPEED))
    |=> !status_oe_i); // R10
  AST_LOW_ADR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && adr < 4'b1001 && !trk_rise_i) |=> $stable(status_oe_i) && $stable(trk_cnt_i)); // R11

endmodule

bind serial_ctrl_port ctrl_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .commit_i     (commit_w),
  .word_i       (word_w),
  .trk_rise_i   (trk_rise_w),
  .trk_cnt_i    (trk_cnt_o),
  .servo_mode_i (servo_mode_o),
  .status_oe_i  (status_oe_o)
);

// File: tb/serial_ctrl_port_tb_top.sv
module serial_ctrl_port_tb_top;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, sdat_i = 1'b0, latch_i = 1'b0, trk_pulse_i = 1'b0, pw_over_i = 1'b0;
  logic [3:0] data_ctrl_o, sync_att_o, servo_tune_o, servo_mode_o;
  logic       double_speed_o, status_o, status_oe_o;
  logic [7:0] trk_cnt_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model
  logic [3:0] m_dc = 0, m_sa = 0, m_tu = 0, m_sm = 0, m_lo = 0, m_hi = 0;
  logic       m_ds = 0;
  logic [7:0] m_cnt = 0;
  int         m_sel = 0; // 0 off, 1 done, 2 busy, 3 pw

  always #10 clk_i = ~clk_i;

  serial_ctrl_port dut_i (
    .clk_i, .rst_ni, .sclk_i, .sdat_i, .latch_i, .trk_pulse_i, .pw_over_i,
    .data_ctrl_o, .sync_att_o, .servo_tune_o, .servo_mode_o, .double_speed_o,
    .trk_cnt_o, .status_o, .status_oe_o
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      sdat_i = w[i];
      wclk(4);
      sclk_i = 1'b1;
      wclk(4);
      sclk_i = 1'b0;
    end
  endtask

  task automatic model_commit(input logic [7:0] w);
    logic [3:0] a, d;
    a = w[7:4];
    d = w[3:0];
    case (a)
      4'h9: begin m_dc = d; m_sel = 0; end
      4'hA: begin m_sa = d; m_sel = 0; end
      4'hB: begin m_lo = d; m_cnt = {m_hi, m_lo}; m_sel = 1; end
      4'hC: begin m_hi = d; m_cnt = {m_hi, m_lo}; m_sel = 2; end
      4'hD: begin m_tu = d; m_sel = 0; end
      4'hE: begin
        if (d inside {4'h0, 4'h5, 4'h6, 4'h8, 4'hA, 4'hC, 4'hE, 4'hF}) m_sm = d;
        m_sel = 3;
      end
      4'hF: begin m_ds = (d[1:0] == 2'b11); m_sel = 0; end
      default: ;
    endcase
  endtask

  task automatic send(input logic [7:0] w);
    shift_word(w);
    latch_i = 1'b1;
    wclk(5);
    latch_i = 1'b0;
    wclk(5);
    model_commit(w);
  endtask

  task automatic pulse();
    trk_pulse_i = 1'b1;
    wclk(5);
    trk_pulse_i = 1'b0;
    wclk(5);
    if (m_cnt != 0) m_cnt = m_cnt - 1;
  endtask

  function automatic logic exp_sts();
    case (m_sel)
      1: return m_cnt != 0;
      2: return m_cnt == 0;
      3: return ~pw_over_i;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk_all(input string req);
    chk({req, " data_ctrl R2"}, data_ctrl_o, m_dc);
    chk({req, " sync_att R2"}, sync_att_o, m_sa);
    chk({req, " tune R2"}, servo_tune_o, m_tu);
    chk({req, " servo R3"}, servo_mode_o, m_sm);
    chk({req, " speed R4"}, double_speed_o, m_ds);
    chk({req, " count R5"}, trk_cnt_o, m_cnt);
    chk({req, " oe R10"}, status_oe_o, m_sel != 0);
    chk({req, " status R8"}, status_o, exp_sts());
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wclk(3);
    rst_ni = 1'b1;
    wclk(2);
    // R12 reset state
    chk("R12 reset", {data_ctrl_o, sync_att_o, servo_tune_o, servo_mode_o}, 16'h0);
    chk("R12 reset speed/count", {double_speed_o, trk_cnt_o}, 9'h0);
    chk("R12 reset oe", status_oe_o, 1'b0);

    // R1 R2 R3 R4 R5 R8 R9 R10: sweep every register address and payload
    for (int a = 9; a < 16; a++) begin
      for (int d = 0; d < 16; d++) begin
        pw_over_i = d[1];
        send({a[3:0], d[3:0]});
        chk_all("R1 sweep");
        pw_over_i = ~pw_over_i;
        wclk(1);
        chk("R10 pw follow", status_o, exp_sts());
      end
    end

    // R11: low addresses ignored
    send(8'hC3);
    send(8'hB7);
    for (int a = 0; a < 9; a++) begin
      send({a[3:0], 4'hA});
      chk_all("R11 low address");
    end

    // R6 counting down and holding at zero, R8 done flag
    send(8'hC0);
    send(8'hB5);
    for (int i = 0; i < 7; i++) begin
      pulse();
      chk("R6 decrement", trk_cnt_o, m_cnt);
      chk("R8 done flag", status_o, exp_sts());
    end
    // R9 busy flag with a two-nibble count
    send(8'hB2);
    send(8'hC1);
    chk("R9 busy", {status_oe_o, status_o}, 2'b10);
    for (int i = 0; i < 20; i++) pulse();
    chk("R6 count 0x12-20", trk_cnt_o, 8'h00);
    chk("R9 idle", status_o, 1'b1);

    // R7 load and pulse in same cycle
    send(8'hC0);
    shift_word(8'hB9);
    latch_i = 1'b1;
    trk_pulse_i = 1'b1;
    wclk(5);
    latch_i = 1'b0;
    trk_pulse_i = 1'b0;
    wclk(5);
    model_commit(8'hB9);
    chk("R7 load wins", trk_cnt_o, 8'h09);
    pulse();
    chk("R7 later pulse", trk_cnt_o, 8'h08);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule